// File: doc/BRIEF.md
# Sequence-Serviced Watchdog Timer

This block is a watchdog peripheral on a 16-bit register bus. Software programs a timeout in half-second units and sets a one-way enable bit. From then on, a down-timing counter advances on every half-second tick strobe. The counter returns to its start only when the service register receives a fixed two-word key pair. If the counter runs out, the block records the cause and raises one of two reset signals. Which one it raises depends on a routing bit: the internal chip reset request or the external reset output.

An optional early-warning interrupt fires a programmable number of half-second units before expiry. Its status flag is cleared by writing 1 to it. Software can also force either reset directly through the control register. After bus reset, a small power-down counter is armed. It pulses the interrupt line low for one clock unless software clears its enable first. A freeze bit, which can be written only once, stops the count while the chip's sleep input is high.

Top module: `wdog_sentry`

## Requirements
- R1: After `rst`, these reads return: control (word 0, byte address 0x0) 0x0030, reset status (address 0x4) 0x0000, interrupt control (address 0x6) 0x0000 and misc (address 0x8) 0x0001. In the same state `irq_n` and `ext_rst_n` are 1 and `int_rst_req` is 0.
- R2: The control register holds the timeout field N in bits 15:8 and enable in bit 2. Once enabled, the timer expires on the (N+1)-th tick after the enable or after the last reload, which is (N+1)/2 seconds. Expiry with routing bit 3 at 0 sets `int_rst_req` after that tick's clock edge and leaves `ext_rst_n` at 1.
- R3: When routing bit 3 is 1, expiry drives `ext_rst_n` low and leaves `int_rst_req` at 0.
- R4: Writing 0x5555 and then 0xAAAA to the service register (address 0x2) reloads the timer. Any other word breaks the sequence, including a second 0x5555. After a break, the tracker again waits for 0x5555.
- R5: Writing 0 to enable does not stop a running timer, and control bit 2 still reads 1. The timeout field can be rewritten while the timer runs, and the new value applies at the next tick.
- R6: The first control write after reset fixes the freeze bit (bit 0). Later writes leave it unchanged. While the freeze bit and `sleep` are both 1, ticks do not advance the timer.
- R7: A control write with bit 4 at 0 sets `int_rst_req`. A control write with bit 5 at 0 drives `ext_rst_n` low. Both work whether or not the timer is enabled. Both bits read back as 1.
- R8: The interrupt control register (address 0x6) has enable in bit 15, status in bit 14 and the pretimeout P in bits 7:0. If enable is 1 and P is not 0, status sets on the tick that leaves P ticks before expiry. While enable and status are both 1, `irq_n` is 0. Writing 1 to bit 14 clears status.
- R9: Bit 1 of reset status (address 0x4) becomes 1 on a timeout expiry. Writes to this register have no effect.
- R10: The timeout status bit, `int_rst_req` and a low `ext_rst_n` hold their values until `rst`. After expiry the timer stops.
- R11: While misc bit 0 is 1, the PD_TICKS-th tick after reset drives `irq_n` low for exactly one clock. Misc bit 0 then reads 0. Writing 0 to misc bit 0 before that tick prevents the pulse.
- R12: A read request returns its data on `bus_rdata` after the next clock edge. Writes take effect at the edge where they are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle half-second strobe |
| sleep | input | 1 | Chip is in low-power state |
| bus_en | input | 1 | Bus access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address, stride 2 |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq_n | output | 1 | Interrupt line, active low |
| int_rst_req | output | 1 | Internal reset request, active high |
| ext_rst_n | output | 1 | External reset output, active low |

## Verification
The assertions take two things for granted. First, `tick` is a single-cycle strobe. Second, `rst` is held for at least two clocks, so the sticky outputs start from their reset values. The stimulus drives `tick` for one clock at a time, with idle clocks between strobes. It also holds reset for several cycles. Random runs keep N small and service the timer before it reaches N+1 ticks. The check therefore lands on a known expiry tick under either routing choice.

// File: rtl/wsv_pkg.sv
package wsv_pkg;
  localparam int unsigned DW = 16;
  localparam logic [2:0] IDX_CTRL = 3'd0;
  localparam logic [2:0] IDX_SVC  = 3'd1;
  localparam logic [2:0] IDX_STAT = 3'd2;
  localparam logic [2:0] IDX_ICTL = 3'd3;
  localparam logic [2:0] IDX_MISC = 3'd4;
  localparam logic [DW-1:0] KEY_FIRST  = 16'h5555;
  localparam logic [DW-1:0] KEY_SECOND = 16'hAAAA;
endpackage

// File: rtl/wsv_seq.sv
module wsv_seq
  import wsv_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_svc,
  input  logic [DW-1:0] wdata,
  output logic          reload
);
  logic armed_q;

  assign reload = wr_svc && armed_q && (wdata == KEY_SECOND);

  always_ff @(posedge clk) begin
    if (rst) armed_q <= 1'b0;
    else if (wr_svc) armed_q <= !armed_q && (wdata == KEY_FIRST);
  end

  // R4
  armed_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (armed_q && !wr_svc) |=> armed_q);
endmodule

// File: rtl/wsv_count.sv
module wsv_count #(
  parameter int unsigned TW = 8,
  parameter int unsigned PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          run,
  input  logic          reload,
  input  logic [TW-1:0] tmo,
  input  logic          pre_en,
  input  logic [PW-1:0] pre,
  output logic          expire,
  output logic          pre_hit
);
  localparam int unsigned EW = ((TW > PW) ? TW : PW) + 2;
  logic [TW:0]   elapsed_q;
  logic [EW-1:0] nxt_w, target_w, sum_w;

  always_comb begin
    nxt_w    = EW'(elapsed_q) + EW'(1);
    target_w = EW'(tmo) + EW'(1);
    sum_w    = nxt_w + EW'(pre);
    expire   = tick && run && (elapsed_q >= {1'b0, tmo});
    pre_hit  = tick && run && !expire && pre_en && (pre != '0) && (sum_w == target_w);
  end

  always_ff @(posedge clk) begin
    if (rst || reload) elapsed_q <= '0;
    else if (tick && run && !expire) elapsed_q <= nxt_w[TW:0];
  end

  // R6
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !reload) |=> $stable(elapsed_q));
endmodule

// File: rtl/wsv_pdown.sv
module wsv_pdown #(
  parameter int unsigned PD_TICKS = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic clr,
  output logic en,
  output logic fire
);
  localparam int unsigned CW = $clog2(PD_TICKS + 1);
  logic [CW-1:0] cnt_q;
  logic          en_q;

  assign en   = en_q;
  assign fire = en_q && !clr && tick && (cnt_q == CW'(PD_TICKS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b1;
      cnt_q <= '0;
    end else if (clr || fire) begin
      en_q  <= 1'b0;
    end else if (tick && en_q) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  // R11
  pd_once_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> !en_q);
endmodule

// File: rtl/wdog_sentry.sv
module wdog_sentry
  import wsv_pkg::*;
#(
  parameter int unsigned TW       = 8,
  parameter int unsigned PW       = 8,
  parameter int unsigned PD_TICKS = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          sleep,
  input  logic          bus_en,
  input  logic          bus_wr,
  input  logic [3:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_n,
  output logic          int_rst_req,
  output logic          ext_rst_n
);
  logic [2:0]    idx;
  logic          wr_ctrl, wr_svc, wr_ictl, wr_misc, rd_req;
  logic [TW-1:0] tmo_q;
  logic          wre_q, wde_q, frz_q, frz_lock_q;
  logic          ie_q, sts_q, tflag_q, irst_q, ern_q, irq_n_q;
  logic [PW-1:0] pre_q;
  logic [DW-1:0] rdata_q, rmux;
  logic          run, reload, expire, pre_hit, pd_en, pd_fire;
  logic          ie_nxt, sts_nxt;

  assign idx     = bus_addr[3:1];
  assign wr_ctrl = bus_en && bus_wr && (idx == IDX_CTRL);
  assign wr_svc  = bus_en && bus_wr && (idx == IDX_SVC);
  assign wr_ictl = bus_en && bus_wr && (idx == IDX_ICTL);
  assign wr_misc = bus_en && bus_wr && (idx == IDX_MISC);
  assign rd_req  = bus_en && !bus_wr;
  assign run     = wde_q && !tflag_q && !(frz_q && sleep);

  wsv_seq u_seq (
    .clk(clk), .rst(rst), .wr_svc(wr_svc), .wdata(bus_wdata), .reload(reload)
  );

  wsv_count #(.TW(TW), .PW(PW)) u_count (
    .clk(clk), .rst(rst), .tick(tick), .run(run), .reload(reload),
    .tmo(tmo_q), .pre_en(ie_q), .pre(pre_q), .expire(expire), .pre_hit(pre_hit)
  );

  wsv_pdown #(.PD_TICKS(PD_TICKS)) u_pdown (
    .clk(clk), .rst(rst), .tick(tick), .clr(wr_misc && !bus_wdata[0]),
    .en(pd_en), .fire(pd_fire)
  );

  always_comb begin
    ie_nxt  = wr_ictl ? bus_wdata[15] : ie_q;
    sts_nxt = (sts_q && !(wr_ictl && bus_wdata[14])) || pre_hit;
    case (idx)
      IDX_CTRL: rmux = {tmo_q, 2'b00, 1'b1, 1'b1, wre_q, wde_q, 1'b0, frz_q};
      IDX_STAT: rmux = {14'd0, tflag_q, 1'b0};
      IDX_ICTL: rmux = {ie_q, sts_q, 6'd0, pre_q};
      IDX_MISC: rmux = {15'd0, pd_en};
      default:  rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tmo_q <= '0; wre_q <= 1'b0; wde_q <= 1'b0;
      frz_q <= 1'b0; frz_lock_q <= 1'b0;
      ie_q <= 1'b0; sts_q <= 1'b0; pre_q <= '0;
      tflag_q <= 1'b0; irst_q <= 1'b0; ern_q <= 1'b1;
      irq_n_q <= 1'b1; rdata_q <= '0;
    end else begin
      if (wr_ctrl) begin
        tmo_q <= bus_wdata[15:8];
        wre_q <= bus_wdata[3];
        if (bus_wdata[2]) wde_q <= 1'b1;
        if (!frz_lock_q) begin
          frz_q      <= bus_wdata[0];
          frz_lock_q <= 1'b1;
        end
        if (!bus_wdata[4]) irst_q <= 1'b1;
        if (!bus_wdata[5]) ern_q  <= 1'b0;
      end
      if (expire) begin
        tflag_q <= 1'b1;
        if (wre_q) ern_q <= 1'b0;
        else       irst_q <= 1'b1;
      end
      if (wr_ictl) pre_q <= bus_wdata[7:0];
      ie_q    <= ie_nxt;
      sts_q   <= sts_nxt;
      irq_n_q <= !((ie_nxt && sts_nxt) || pd_fire);
      if (rd_req) rdata_q <= rmux;
    end
  end

  assign bus_rdata   = rdata_q;
  assign irq_n       = irq_n_q;
  assign int_rst_req = irst_q;
  assign ext_rst_n   = ern_q;

  // R5
  enable_stuck_chk: assert property (@(posedge clk) disable iff (rst)
    wde_q |=> wde_q);
  // R6
  freeze_once_chk: assert property (@(posedge clk) disable iff (rst)
    frz_lock_q |=> $stable(frz_q));
  // R10
  tflag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    tflag_q |=> tflag_q);
  // R10
  irst_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    int_rst_req |=> int_rst_req);
  // R10
  ern_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !$rose(ext_rst_n));
  // R2
  stop_after_chk: assert property (@(posedge clk) disable iff (rst)
    tflag_q |-> !expire);
endmodule

// File: tb/test_wdog_sentry.sv
module test_wdog_sentry;
  localparam int PD = 64;
  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, sleep = 1'b0;
  logic bus_en = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic irq_n, int_rst_req, ext_rst_n;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  wdog_sentry #(.PD_TICKS(PD)) i_wdog_sentry (
    .clk(clk), .rst(rst), .tick(tick), .sleep(sleep), .bus_en(bus_en),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_n(irq_n), .int_rst_req(int_rst_req),
    .ext_rst_n(ext_rst_n)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; tick = 1'b0; sleep = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_en = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk); d = bus_rdata; bus_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic service();
    wr(4'h2, 16'h5555); wr(4'h2, 16'hAAAA);
  endtask

  // expected {int_rst_req, ext_rst_n} after expiry for a routing choice
  function automatic logic [1:0] exp_fire(input logic route);
    return route ? 2'b00 : 2'b11;
  endfunction

  function automatic logic [15:0] ctrl_word(input logic [7:0] n, input logic route,
                                            input logic en, input logic frz);
    return {n, 2'b00, 1'b1, 1'b1, route, en, 1'b0, frz};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'd4242));
    // R1 reset state, R12 read timing
    do_reset();
    rd(4'h0, d); chk("R1 ctrl", d, 16'h0030);
    rd(4'h4, d); chk("R1 stat", d, 16'h0000);
    rd(4'h6, d); chk("R1 ictl", d, 16'h0000);
    rd(4'h8, d); chk("R12 misc", d, 16'h0001);
    chk("R1 pins", {13'd0, irq_n, int_rst_req, ext_rst_n}, 16'h0005);

    // R2 internal reset on expiry, R9 status, R10 sticky
    do_reset(); wr(4'h8, 16'h0000);
    wr(4'h0, ctrl_word(8'd3, 1'b0, 1'b1, 1'b0));
    ticks(3); chk("R2 before", {15'd0, int_rst_req}, 16'h0000);
    ticks(1); chk("R2 expire", {14'd0, int_rst_req, ext_rst_n}, 16'h0003);
    rd(4'h4, d); chk("R9 stat", d, 16'h0002);
    wr(4'h4, 16'h0000); rd(4'h4, d); chk("R9 readonly", d, 16'h0002);
    ticks(5); chk("R10 sticky", {14'd0, int_rst_req, ext_rst_n}, 16'h0003);

    // R3 external routing
    do_reset(); wr(4'h8, 16'h0000);
    wr(4'h0, ctrl_word(8'd3, 1'b1, 1'b1, 1'b0));
    ticks(3); chk("R3 before", {15'd0, ext_rst_n}, 16'h0001);
    ticks(1); chk("R3 expire", {14'd0, int_rst_req, ext_rst_n}, 16'h0000);

    // R4 good sequence reloads
    do_reset(); wr(4'h8, 16'h0000);
    wr(4'h0, ctrl_word(8'd3, 1'b0, 1'b1, 1'b0));
    ticks(3); service(); ticks(3);
    chk("R4 reloaded", {15'd0, int_rst_req}, 16'h0000);
    ticks(1); chk("R4 after reload", {15'd0, int_rst_req}, 16'h0001);
    // R4 broken sequences do not reload
    do_reset(); wr(4'h8, 16'h0000);
    wr(4'h0, ctrl_word(8'd3, 1'b0, 1'b1, 1'b0));
    ticks(2); wr(4'h2, 16'h5555); wr(4'h2, 16'h1234); wr(4'h2, 16'hAAAA);
    ticks(2); chk("R4 broken", {15'd0, int_rst_req}, 16'h0001);
    do_reset(); wr(4'h8, 16'h0000);
    wr(4'h0, ctrl_word(8'd3, 1'b0, 1'b1, 1'b0));
    ticks(2); wr(4'h2, 16'h5555); wr(4'h2, 16'h5555); wr(4'h2, 16'hAAAA);
    ticks(2); chk("R4 double key", {15'd0, int_rst_req}, 16'h0001);

    // R5 enable cannot be cleared
    do_reset(); wr(4'h8, 16'h0000);
    wr(4'h0, ctrl_word(8'd3, 1'b0, 1'b1, 1'b0));
    ticks(2); wr(4'h0, ctrl_word(8'd3, 1'b0, 1'b0, 1'b0));
    rd(4'h0, d); chk("R5 enable stuck", d, 16'h0334);
    ticks(1); chk("R5 still counting a", {15'd0, int_rst_req}, 16'h0000);
    ticks(1); chk("R5 still counting b", {15'd0, int_rst_req}, 16'h0001);
    // R5 timeout rewrite while running
    do_reset(); wr(4'h8, 16'h0000);
    wr(4'h0, ctrl_word(8'd9, 1'b0, 1'b1, 1'b0));
    ticks(2); wr(4'h0, ctrl_word(8'd1, 1'b0, 1'b1, 1'b0));
    ticks(1); chk("R5 rewrite", {15'd0, int_rst_req}, 16'h0001);

    // R6 freeze with sleep
    do_reset(); wr(4'h8, 16'h0000);
    wr(4'h0, ctrl_word(8'd3, 1'b0, 1'b1, 1'b1));
    sleep = 1'b1; ticks(10);
    chk("R6 frozen", {15'd0, int_rst_req}, 16'h0000);
    sleep = 1'b0; ticks(3); chk("R6 thaw a", {15'd0, int_rst_req}, 16'h0000);
    ticks(1); chk("R6 thaw b", {15'd0, int_rst_req}, 16'h0001);
    // R6 write-once
    do_reset(); wr(4'h8, 16'h0000);
    wr(4'h0, ctrl_word(8'd3, 1'b0, 1'b0, 1'b0));
    wr(4'h0, ctrl_word(8'd3, 1'b0, 1'b1, 1'b1));
    rd(4'h0, d); chk("R6 once", d, 16'h0334);
    sleep = 1'b1; ticks(4);
    chk("R6 not frozen", {15'd0, int_rst_req}, 16'h0001);
    sleep = 1'b0;

    // R7 software resets
    do_reset(); wr(4'h8, 16'h0000);
    wr(4'h0, 16'h0020);
    chk("R7 internal", {14'd0, int_rst_req, ext_rst_n}, 16'h0003);
    rd(4'h0, d); chk("R7 readback", d, 16'h0030);
    do_reset(); wr(4'h8, 16'h0000);
    wr(4'h0, 16'h0010);
    chk("R7 external", {14'd0, int_rst_req, ext_rst_n}, 16'h0000);

    // R8 pretimeout interrupt
    do_reset(); wr(4'h8, 16'h0000);
    wr(4'h6, 16'h8003);
    wr(4'h0, ctrl_word(8'd9, 1'b0, 1'b1, 1'b0));
    ticks(6); chk("R8 early", {15'd0, irq_n}, 16'h0001);
    ticks(1); chk("R8 fire", {15'd0, irq_n}, 16'h0000);
    rd(4'h6, d); chk("R8 status", d, 16'hC003);
    wr(4'h6, 16'hC003); chk("R8 cleared pin", {15'd0, irq_n}, 16'h0001);
    rd(4'h6, d); chk("R8 cleared reg", d, 16'h8003);

    // R11 power-down pulse
    do_reset();
    ticks(PD - 1); chk("R11 before", {15'd0, irq_n}, 16'h0001);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0; chk("R11 pulse", {15'd0, irq_n}, 16'h0000);
    @(negedge clk); chk("R11 one clock", {15'd0, irq_n}, 16'h0001);
    rd(4'h8, d); chk("R11 misc off", d, 16'h0000);
    // R11 cleared misc prevents pulse
    do_reset(); wr(4'h8, 16'h0000);
    begin
      int lows = 0;
      for (int i = 0; i < PD + 2; i++) begin
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        if (irq_n !== 1'b1) lows++;
      end
      chk("R11 disabled", 16'(lows), 16'h0000);
    end

    // R2 R3 R4 random timeouts, routing and service points
    for (int it = 0; it < 16; it++) begin
      int n, k;
      logic route;
      n = 1 + int'($urandom % 12);
      k = int'($urandom % (n + 1));
      route = 1'($urandom % 2);
      do_reset(); wr(4'h8, 16'h0000);
      wr(4'h0, ctrl_word(8'(n), route, 1'b1, 1'b0));
      ticks(k); service(); ticks(n);
      chk("R4 rand hold", {14'd0, int_rst_req, ext_rst_n}, 16'h0001);
      ticks(1);
      chk(route ? "R3 rand fire" : "R2 rand fire",
          {14'd0, int_rst_req, ext_rst_n}, {14'd0, exp_fire(route)});
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule